// File: doc/BRIEF.md
# Host Decode and Compatibility Router

This block sits in a host bridge on the path of outgoing memory and I/O requests. It decides which downstream I/O chain receives each request. A table of programmable windows records the positive-decode address ranges of the devices and bridges on every chain. Each incoming address is compared against every window in the same cycle. When a window hits, the request goes to the chain that owns the window, with its compatibility flag cleared. When no window hits, the request is sent to one fixed compatibility chain with the flag set. That chain carries the subtractive bridge, which then claims the request whatever its address.

Requests enter through a valid/ready handshake and carry an address and a space bit (memory or I/O). Software fills the table through a write port that loads one whole window per cycle. A second write port picks the compatibility chain. Each chain has its own valid/ready output carrying the address, the space bit and the compatibility flag. One register stage sits between input and outputs. A stalled chain holds its request and stops the input.

Top module: `host_route_decoder`

## Requirements
- R1: After reset no output is valid, `req_ready` is high, every window is disabled and the compatibility chain is chain 0. A request made straight after reset therefore leaves on chain 0 with `out_compat` = 1.
- R2: A window hits a request when the window is enabled, its space bit equals `req_is_io`, and `base <= addr <= limit`, with both bounds inclusive. A hit request leaves on the window's chain with `out_compat` = 0.
- R3: A request that no window hits leaves on the chain currently selected as the compatibility chain, with `out_compat` = 1.
- R4: When several windows hit the same request, the window with the lowest index decides the chain.
- R5: A window whose space bit is 0 (memory) never hits an I/O request (`req_is_io` = 1), and a window whose space bit is 1 never hits a memory request.
- R6: A window whose enable bit is 0 never hits any request.
- R7: `cfg_compat_chain` can select any chain as the compatibility chain. A window may target that same chain, and a request that hits such a window leaves there with `out_compat` = 0.
- R8: A request accepted at a clock edge appears on its chain's port from that edge on. It carries `req_addr` and `req_is_io` unchanged. It is decoded against the table as it stood before that edge.
- R9: No more than one `out_valid` bit is high at a time. While the valid chain has `out_ready` low, its outputs stay unchanged and `req_ready` is low, whatever the other chains' ready inputs are. Each accepted request is presented exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_addr | input | ADDR_W | Request address |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| cfg_entry_we | input | 1 | Write one window |
| cfg_entry_idx | input | $clog2(N_WIN) | Window index written |
| cfg_base | input | ADDR_W | Lower bound, inclusive |
| cfg_limit | input | ADDR_W | Upper bound, inclusive |
| cfg_is_io | input | 1 | Window space: 1 = I/O, 0 = memory |
| cfg_chain | input | $clog2(N_CHAIN) | Chain owning the window |
| cfg_enable | input | 1 | Window enable |
| cfg_compat_we | input | 1 | Write compatibility chain select |
| cfg_compat_chain | input | $clog2(N_CHAIN) | Compatibility chain index |
| out_valid | output | N_CHAIN | Per-chain request valid |
| out_ready | input | N_CHAIN | Per-chain ready |
| out_addr | output | N_CHAIN x ADDR_W | Per-chain address |
| out_is_io | output | N_CHAIN | Per-chain space bit |
| out_compat | output | N_CHAIN | Per-chain compatibility flag |

## Verification
Each routing result is due one edge after acceptance. The bench drives inputs on the falling edge and reads the chain ports on the next falling edge, after the single accepting rising edge. Table and compatibility writes take effect at their own rising edge, so a sweep starts only one falling edge after the last write. Under backpressure, the held request and a low `req_ready` are checked on several falling edges in a row. When the right ready rises, the following request is due one edge later, and the bench then checks on the next falling edge that no valid output remains.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
   typedef enum logic {
      SPACE_MEM = 1'b0,
      SPACE_IO  = 1'b1
   } space_e;

   function automatic logic in_window(input logic [63:0] a,
                                      input logic [63:0] lo,
                                      input logic [63:0] hi);
      return (a >= lo) && (a <= hi);
   endfunction
endpackage

// File: rtl/hdr_range_table.sv
module hdr_range_table #(
   parameter int ADDR_W = 32,
   parameter int N_WIN  = 8,
   parameter int CHW    = 2,
   localparam int IW    = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IW-1:0]                 wr_idx,
   input  logic [ADDR_W-1:0]             wr_base,
   input  logic [ADDR_W-1:0]             wr_limit,
   input  logic                          wr_io,
   input  logic [CHW-1:0]                wr_chain,
   input  logic                          wr_on,
   output logic [N_WIN-1:0][ADDR_W-1:0]  t_base,
   output logic [N_WIN-1:0][ADDR_W-1:0]  t_limit,
   output logic [N_WIN-1:0]              t_io,
   output logic [N_WIN-1:0][CHW-1:0]     t_chain,
   output logic [N_WIN-1:0]              t_on
);
   for (genvar w = 0; w < N_WIN; w++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            t_base[w]  <= '0;
            t_limit[w] <= '0;
            t_io[w]    <= 1'b0;
            t_chain[w] <= '0;
            t_on[w]    <= 1'b0;
         end else if (wr_en && (wr_idx == IW'(w))) begin
            t_base[w]  <= wr_base;
            t_limit[w] <= wr_limit;
            t_io[w]    <= wr_io;
            t_chain[w] <= wr_chain;
            t_on[w]    <= wr_on;
         end
      end
   end

   // R6: a window written with enable low stays silent afterwards
   assert_disable_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_on) |=> !t_on[$past(wr_idx)]);
endmodule

// File: rtl/hdr_range_match.sv
module hdr_range_match
   import hdr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int N_WIN  = 8,
   parameter int CHW    = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             addr,
   input  logic                          is_io,
   input  logic [N_WIN-1:0][ADDR_W-1:0]  t_base,
   input  logic [N_WIN-1:0][ADDR_W-1:0]  t_limit,
   input  logic [N_WIN-1:0]              t_io,
   input  logic [N_WIN-1:0][CHW-1:0]     t_chain,
   input  logic [N_WIN-1:0]              t_on,
   output logic                          hit,
   output logic [CHW-1:0]                hit_chain
);
   logic [N_WIN-1:0] hv;

   for (genvar w = 0; w < N_WIN; w++) begin : g_cmp
      assign hv[w] = t_on[w] && (t_io[w] == is_io) &&
                     in_window(64'(addr), 64'(t_base[w]), 64'(t_limit[w]));
   end

   always_comb begin
      hit       = 1'b0;
      hit_chain = '0;
      for (int w = N_WIN - 1; w >= 0; w--) begin
         if (hv[w]) begin
            hit       = 1'b1;
            hit_chain = t_chain[w];
         end
      end
   end

   // R2: a reported hit always names the chain of some hitting window
   assert_hit_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (hv != '0));
   // R4: window 0 hitting fixes the chain to window 0's chain
   assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hv[0] |-> (hit_chain == t_chain[0]));
endmodule

// File: rtl/hdr_route_stage.sv
module hdr_route_stage #(
   parameter int ADDR_W  = 32,
   parameter int N_CHAIN = 4,
   parameter int CHW     = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   output logic                            in_ready,
   input  logic [ADDR_W-1:0]               in_addr,
   input  logic                            in_io,
   input  logic [CHW-1:0]                  in_chain,
   input  logic                            in_compat,
   output logic [N_CHAIN-1:0]              out_valid,
   input  logic [N_CHAIN-1:0]              out_ready,
   output logic [N_CHAIN-1:0][ADDR_W-1:0]  out_addr,
   output logic [N_CHAIN-1:0]              out_is_io,
   output logic [N_CHAIN-1:0]              out_compat
);
   logic              h_v;
   logic [ADDR_W-1:0] h_addr;
   logic              h_io;
   logic [CHW-1:0]    h_chain;
   logic              h_compat;

   assign in_ready = !h_v || out_ready[h_chain];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_v      <= 1'b0;
         h_addr   <= '0;
         h_io     <= 1'b0;
         h_chain  <= '0;
         h_compat <= 1'b0;
      end else if (in_ready) begin
         h_v <= in_valid;
         if (in_valid) begin
            h_addr   <= in_addr;
            h_io     <= in_io;
            h_chain  <= in_chain;
            h_compat <= in_compat;
         end
      end
   end

   for (genvar c = 0; c < N_CHAIN; c++) begin : g_port
      assign out_valid[c]  = h_v && (h_chain == CHW'(c));
      assign out_addr[c]   = h_addr;
      assign out_is_io[c]  = h_io;
      assign out_compat[c] = h_compat;

      // R9: a stalled chain keeps its request unchanged
      assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[c] && !out_ready[c]) |=>
            (out_valid[c] && $stable(out_addr[c]) && $stable(out_compat[c])));
   end

   // R9: at most one chain sees a request
   assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_valid));
   // R9: input closed while the presented request is not taken
   assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_valid != '0) && ((out_valid & out_ready) == '0)) |-> !in_ready);
   // R8: an accepted request is presented after one edge
   assert_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> ((out_valid != '0) && (out_addr[h_chain] == $past(in_addr))));
endmodule

// File: rtl/host_route_decoder.sv
module host_route_decoder #(
   parameter int ADDR_W  = 32,
   parameter int N_WIN   = 8,
   parameter int N_CHAIN = 4,
   localparam int IW     = (N_WIN > 1) ? $clog2(N_WIN) : 1,
   localparam int CHW    = (N_CHAIN > 1) ? $clog2(N_CHAIN) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   output logic                            req_ready,
   input  logic [ADDR_W-1:0]               req_addr,
   input  logic                            req_is_io,
   input  logic                            cfg_entry_we,
   input  logic [IW-1:0]                   cfg_entry_idx,
   input  logic [ADDR_W-1:0]               cfg_base,
   input  logic [ADDR_W-1:0]               cfg_limit,
   input  logic                            cfg_is_io,
   input  logic [CHW-1:0]                  cfg_chain,
   input  logic                            cfg_enable,
   input  logic                            cfg_compat_we,
   input  logic [CHW-1:0]                  cfg_compat_chain,
   output logic [N_CHAIN-1:0]              out_valid,
   input  logic [N_CHAIN-1:0]              out_ready,
   output logic [N_CHAIN-1:0][ADDR_W-1:0]  out_addr,
   output logic [N_CHAIN-1:0]              out_is_io,
   output logic [N_CHAIN-1:0]              out_compat
);
   initial begin
      if (ADDR_W < 1 || ADDR_W > 64) $fatal(1, "ADDR_W must lie in 1..64");
      if (N_WIN < 1)                 $fatal(1, "N_WIN must be at least 1");
      if (N_CHAIN < 2)               $fatal(1, "N_CHAIN must be at least 2");
      if ((1 << CHW) != N_CHAIN)     $fatal(1, "N_CHAIN must be a power of two");
   end

   logic [N_WIN-1:0][ADDR_W-1:0] t_base;
   logic [N_WIN-1:0][ADDR_W-1:0] t_limit;
   logic [N_WIN-1:0]             t_io;
   logic [N_WIN-1:0][CHW-1:0]    t_chain;
   logic [N_WIN-1:0]             t_on;
   logic [CHW-1:0]               compat_q;
   logic                         m_hit;
   logic [CHW-1:0]               m_chain;
   logic [CHW-1:0]               sel_chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             compat_q <= '0;
      else if (cfg_compat_we) compat_q <= cfg_compat_chain;
   end

   hdr_range_table #(.ADDR_W(ADDR_W), .N_WIN(N_WIN), .CHW(CHW)) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_entry_we), .wr_idx(cfg_entry_idx), .wr_base(cfg_base),
      .wr_limit(cfg_limit), .wr_io(cfg_is_io), .wr_chain(cfg_chain), .wr_on(cfg_enable),
      .t_base(t_base), .t_limit(t_limit), .t_io(t_io), .t_chain(t_chain), .t_on(t_on)
   );

   hdr_range_match #(.ADDR_W(ADDR_W), .N_WIN(N_WIN), .CHW(CHW)) u_match (
      .clk(clk), .rst_n(rst_n),
      .addr(req_addr), .is_io(req_is_io),
      .t_base(t_base), .t_limit(t_limit), .t_io(t_io), .t_chain(t_chain), .t_on(t_on),
      .hit(m_hit), .hit_chain(m_chain)
   );

   assign sel_chain = m_hit ? m_chain : compat_q;

   hdr_route_stage #(.ADDR_W(ADDR_W), .N_CHAIN(N_CHAIN), .CHW(CHW)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .in_valid(req_valid), .in_ready(req_ready), .in_addr(req_addr), .in_io(req_is_io),
      .in_chain(sel_chain), .in_compat(!m_hit),
      .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
      .out_is_io(out_is_io), .out_compat(out_compat)
   );

   // R3: a missed request lands flagged on the compatibility chain of its accept cycle
   assert_miss_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !m_hit) |=>
         ((out_valid == (N_CHAIN'(1) << $past(compat_q))) && ((out_valid & out_compat) != '0)));
   // R7: a hit never carries the flag, even on the compatibility chain
   assert_hit_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && m_hit) |=> ((out_valid & out_compat) == '0));
endmodule

// File: tb/host_route_decoder_bench.sv
module host_route_decoder_bench;
   localparam int AW = 32;
   localparam int NW = 8;
   localparam int NC = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic                    req_valid = 1'b0;
   logic                    req_ready;
   logic [AW-1:0]           req_addr = '0;
   logic                    req_is_io = 1'b0;
   logic                    cfg_entry_we = 1'b0;
   logic [2:0]              cfg_entry_idx = '0;
   logic [AW-1:0]           cfg_base = '0;
   logic [AW-1:0]           cfg_limit = '0;
   logic                    cfg_is_io = 1'b0;
   logic [1:0]              cfg_chain = '0;
   logic                    cfg_enable = 1'b0;
   logic                    cfg_compat_we = 1'b0;
   logic [1:0]              cfg_compat_chain = '0;
   logic [NC-1:0]           out_valid;
   logic [NC-1:0]           out_ready = '1;
   logic [NC-1:0][AW-1:0]   out_addr;
   logic [NC-1:0]           out_is_io;
   logic [NC-1:0]           out_compat;

   host_route_decoder #(.ADDR_W(AW), .N_WIN(NW), .N_CHAIN(NC)) u_host_route_decoder (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_is_io(req_is_io),
      .cfg_entry_we(cfg_entry_we), .cfg_entry_idx(cfg_entry_idx), .cfg_base(cfg_base),
      .cfg_limit(cfg_limit), .cfg_is_io(cfg_is_io), .cfg_chain(cfg_chain), .cfg_enable(cfg_enable),
      .cfg_compat_we(cfg_compat_we), .cfg_compat_chain(cfg_compat_chain),
      .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
      .out_is_io(out_is_io), .out_compat(out_compat)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [AW-1:0] m_base  [NW];
   logic [AW-1:0] m_limit [NW];
   logic          m_io    [NW];
   logic [1:0]    m_chain [NW];
   logic          m_on    [NW];
   logic [1:0]    m_compat;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic write_win(input int i, input logic [AW-1:0] b, input logic [AW-1:0] l,
                            input logic io, input logic [1:0] ch, input logic en);
      cfg_entry_we = 1'b1; cfg_entry_idx = 3'(i); cfg_base = b; cfg_limit = l;
      cfg_is_io = io; cfg_chain = ch; cfg_enable = en;
      @(negedge clk);
      cfg_entry_we = 1'b0;
      m_base[i] = b; m_limit[i] = l; m_io[i] = io; m_chain[i] = ch; m_on[i] = en;
   endtask

   task automatic write_compat(input logic [1:0] ch);
      cfg_compat_we = 1'b1; cfg_compat_chain = ch;
      @(negedge clk);
      cfg_compat_we = 1'b0;
      m_compat = ch;
   endtask

   // expected route from the requirement text: lowest enabled window of same space
   task automatic expect_route(input logic [AW-1:0] a, input logic io,
                               output logic [1:0] ch, output logic cf);
      ch = m_compat; cf = 1'b1;
      for (int i = NW - 1; i >= 0; i--) begin
         if (m_on[i] && m_io[i] == io && a >= m_base[i] && a <= m_limit[i]) begin
            ch = m_chain[i]; cf = 1'b0;
         end
      end
   endtask

   // called on a falling edge with all out_ready high; returns on the next falling edge
   task automatic send(input logic [AW-1:0] a, input logic io, input string req);
      logic [1:0] ech;
      logic       ecf;
      expect_route(a, io, ech, ecf);
      req_valid = 1'b1; req_addr = a; req_is_io = io;
      @(negedge clk);
      req_valid = 1'b0;
      check(out_valid == (NC'(1) << ech) && out_addr[ech] == a &&
            out_is_io[ech] == io && out_compat[ech] == ecf,
            req, $sformatf("route addr %0h io %0d {valid,compat}", a, io),
            {out_valid, out_compat}, {NC'(1) << ech, ecf ? (NC'(1) << ech) : NC'(0)});
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NW; i++) begin
         m_base[i] = '0; m_limit[i] = '0; m_io[i] = 1'b0; m_chain[i] = '0; m_on[i] = 1'b0;
      end
      m_compat = 2'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state and empty-table routing
      check(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);
      check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
      send(32'h0000_1234, 1'b0, "R1");
      send(32'h0000_0010, 1'b1, "R1");

      // configuration A: overlaps, single-address, disabled and I/O windows
      write_win(0, 32'h10, 32'h1F, 1'b0, 2'd1, 1'b1);
      write_win(1, 32'h18, 32'h3F, 1'b0, 2'd2, 1'b1);
      write_win(2, 32'h20, 32'h2F, 1'b1, 2'd3, 1'b1);
      write_win(3, 32'h80, 32'h80, 1'b0, 2'd3, 1'b1);
      write_win(4, 32'h40, 32'h7F, 1'b0, 2'd3, 1'b0);
      write_win(7, 32'hF0, 32'hFF, 1'b1, 2'd2, 1'b1);
      for (int a = 0; a < 256; a++) send(AW'(a), 1'b0, "R2/R3/R4/R6");
      for (int a = 0; a < 256; a++) send(AW'(a), 1'b1, "R5/R2/R3");
      send(32'hFFFF_FFFF, 1'b0, "R3");
      send(32'h0000_0118, 1'b0, "R3");

      // R8: write in the accepting cycle: old table applies
      cfg_entry_we = 1'b1; cfg_entry_idx = 3'd6; cfg_base = 32'h200; cfg_limit = 32'h2FF;
      cfg_is_io = 1'b0; cfg_chain = 2'd2; cfg_enable = 1'b1;
      send(32'h250, 1'b0, "R8");
      cfg_entry_we = 1'b0;
      m_base[6] = 32'h200; m_limit[6] = 32'h2FF; m_io[6] = 1'b0; m_chain[6] = 2'd2; m_on[6] = 1'b1;
      send(32'h250, 1'b0, "R8");

      // R9: backpressure on chain 1 while other chains are ready
      out_ready = 4'b0101;
      req_valid = 1'b1; req_addr = 32'h15; req_is_io = 1'b0;
      @(negedge clk);
      req_addr = 32'h05;
      for (int k = 0; k < 3; k++) begin
         check(out_valid == 4'b0010 && out_addr[1] == 32'h15 && out_compat[1] == 1'b0,
               "R9", "held request", {out_valid, out_addr[1]}, {4'b0010, 32'h15});
         check(req_ready == 1'b0, "R9", "req_ready during stall", req_ready, 0);
         @(negedge clk);
      end
      out_ready = 4'b0010;
      @(negedge clk);
      out_ready = '1;
      req_valid = 1'b0;
      check(out_valid == 4'b0001 && out_addr[0] == 32'h05 && out_compat[0] == 1'b1,
            "R9", "next request after release", {out_valid, out_compat}, {4'b0001, 4'b0001});
      @(negedge clk);
      check(out_valid == '0, "R9", "no duplicate presentation", out_valid, 0);

      // configuration B: compatibility chain 3, window on that same chain
      write_compat(2'd3);
      write_win(5, 32'h40, 32'h4F, 1'b0, 2'd3, 1'b1);
      write_win(0, 32'h10, 32'h1F, 1'b0, 2'd1, 1'b0);
      for (int a = 0; a < 256; a++) send(AW'(a), 1'b0, "R7/R3/R6");
      for (int a = 0; a < 256; a += 4) send(AW'(a), 1'b1, "R7/R5");
      send(32'h48, 1'b0, "R7");
      send(32'h50, 1'b0, "R7");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule